// File: doc/BRIEF.md
# Two-Sided Processor Mailbox

A register-mapped mailbox that joins two processors, called side A and side B. Each side has its own register port. A side pushes a 32-bit word into one of four outgoing slots, and the word becomes readable in the slot with the same index on the other side. Status flags on both sides follow each slot: the sender sees whether its slot has been drained, and the receiver sees whether a fresh word is waiting. Reading the word drains the slot.

Alongside the data path, each direction has four doorbells. A doorbell raises an event on the peer without carrying data, and the peer acknowledges it with a write-one-to-clear. Every event kind has a per-index enable, and each side has one interrupt line. Side A can also start a unit reset. The reset wipes both halves and shows a busy bit for a short window. All field positions use a reversed-index layout, so index 0 sits at the top bit of each 4-bit field.

Top module: `ipc_mailbox`

## Requirements
- R1: A word written to outgoing slot n (byte offset 0x00+4n) on one side is returned by a read of incoming slot n (offset 0x10+4n) on the other side. A read of a side's own outgoing slot returns the last word that side wrote there.
- R2: In the status word (offset 0x20), the slot-drained flag for index n sits at bit 20+(3-n) and the word-waiting flag at bit 24+(3-n). Writing outgoing slot n clears the writer's drained flag n and sets the peer's waiting flag n, effective from the next cycle.
- R3: Reading incoming slot n clears that side's waiting flag n and sets the sender's drained flag n again, effective from the next cycle.
- R4: Writing an outgoing slot whose drained flag is 0 replaces the word and leaves both flags unchanged. Reading an incoming slot whose waiting flag is 0 returns the previous word and changes no flag.
- R5: In the control word (offset 0x24), writing 1 to doorbell request bit 16+(3-n) makes that bit read 1 for exactly one cycle. It then reads 0, and the peer's doorbell-pending bit 28+(3-n) is set from that next cycle on.
- R6: Writing 1 to a doorbell-pending bit in the status word clears it. Writing 0 leaves it as it was.
- R7: A side's interrupt output is high exactly when some pending, waiting or drained event bit is 1 and its enable is 1. The enables sit in the control word at bits 28+(3-n) (doorbell), 24+(3-n) (incoming) and 20+(3-n) (drained).
- R8: After power-on reset, the status word reads 0x00F00000 on both sides, the control word reads 0, and both interrupt outputs are low.
- R9: Writing 1 to control bit 5 on side A clears all slots, flags, enables and requests on both sides. Status bit 7 then reads 1 on both sides for RST_CYCLES cycles, and all register accesses in that window are ignored. Control bit 5 on side B has no effect, and bit 5 always reads 0.
- R10: The enable fields of the control word read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its default RST_CYCLES of 4. With a window that short, every busy cycle of a unit reset can be inspected one at a time, and so can a peer write attempted in the middle of it. The bench also keeps a behavioural model of both halves and compares both read buses and both interrupt lines with it on every clock. Collisions between the two sides in the same cycle, such as doorbell set against clear or a fill against a drain, are therefore checked wherever they occur.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_sel,
  input  logic        a_wr,
  input  logic [5:0]  a_addr,
  input  logic [31:0] a_wdata,
  output logic [31:0] a_rdata,
  output logic        a_irq,
  input  logic        b_sel,
  input  logic        b_wr,
  input  logic [5:0]  b_addr,
  input  logic [31:0] b_wdata,
  output logic [31:0] b_rdata,
  output logic        b_irq
);
  localparam int NSLOT = 4;
  localparam int CW = $clog2(RST_CYCLES + 1);

  function automatic logic [3:0] flip(input logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  logic [1:0]             sel, wr, irq;
  logic [1:0][5:0]        addr;
  logic [1:0][31:0]       wdata, rdata;

  assign sel   = {b_sel, a_sel};
  assign wr    = {b_wr, a_wr};
  assign addr  = {b_addr, a_addr};
  assign wdata = {b_wdata, a_wdata};
  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_irq = irq[0];
  assign b_irq = irq[1];

  logic [1:0][NSLOT-1:0][31:0] slot;
  logic [1:0][NSLOT-1:0]       full, gip, gie, rie, tie, gir;
  logic [CW-1:0]               rst_cnt;
  logic                        busy;

  logic [1:0][NSLOT-1:0]       tx_we, rx_re;
  logic [1:0]                  st_we, ct_we;
  logic [1:0][31:0]            stat_w, ctrl_w;
  logic                        rst_go;

  assign busy = (rst_cnt != '0);

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      stat_w[s] = {flip(gip[s]), flip(full[1-s]), flip(~full[s]), 12'b0, busy, 7'b0};
      ctrl_w[s] = {flip(gie[s]), flip(rie[s]), flip(tie[s]), flip(gir[s]), 16'b0};
      st_we[s]  = sel[s] & ~busy & wr[s] & (addr[s][5:2] == 4'b1000);
      ct_we[s]  = sel[s] & ~busy & wr[s] & (addr[s][5:2] == 4'b1001);
      for (int n = 0; n < NSLOT; n++) begin
        tx_we[s][n] = sel[s] & ~busy & wr[s]  & (addr[s][5:4] == 2'b00) & (addr[s][3:2] == 2'(n));
        rx_re[s][n] = sel[s] & ~busy & ~wr[s] & (addr[s][5:4] == 2'b01) & (addr[s][3:2] == 2'(n));
      end
      case (addr[s][5:4])
        2'b00:   rdata[s] = slot[s][addr[s][3:2]];
        2'b01:   rdata[s] = slot[1-s][addr[s][3:2]];
        2'b10:   rdata[s] = (addr[s][3:2] == 2'b00) ? stat_w[s] :
                            (addr[s][3:2] == 2'b01) ? ctrl_w[s] : 32'h0;
        default: rdata[s] = 32'h0;
      endcase
      irq[s] = |(gip[s] & gie[s]) | |(full[1-s] & rie[s]) | |(~full[s] & tie[s]);
    end
  end

  assign rst_go = ct_we[0] & wdata[0][5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0; full <= '0; gip <= '0;
      gie <= '0; rie <= '0; tie <= '0; gir <= '0;
      rst_cnt <= '0;
    end else if (rst_go) begin
      slot <= '0; full <= '0; gip <= '0;
      gie <= '0; rie <= '0; tie <= '0; gir <= '0;
      rst_cnt <= CW'(RST_CYCLES);
    end else begin
      if (busy) rst_cnt <= rst_cnt - 1'b1;
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < NSLOT; n++) begin
          if (tx_we[s][n]) slot[s][n] <= wdata[s];
          if (tx_we[s][n])          full[s][n] <= 1'b1;
          else if (rx_re[1-s][n])   full[s][n] <= 1'b0;
          if (gir[1-s][n])                        gip[s][n] <= 1'b1;
          else if (st_we[s] && wdata[s][31-n])    gip[s][n] <= 1'b0;
        end
        if (ct_we[s]) begin
          gie[s] <= flip(wdata[s][31:28]);
          rie[s] <= flip(wdata[s][27:24]);
          tie[s] <= flip(wdata[s][23:20]);
          gir[s] <= flip(wdata[s][19:16]);
        end else begin
          gir[s] <= '0;
        end
      end
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_chk
    AST_FILL_SETS_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      tx_we[0][n] |=> full[0][n]); // R2
    AST_DRAIN_CLEARS_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      rx_re[1][n] && !tx_we[0][n] |=> !full[0][n]); // R3
    AST_BELL_REACHES_PEER: assert property (@(posedge clk) disable iff (!rst_n)
      gir[0][n] && !rst_go |=> gip[1][n]); // R5
    AST_BELL_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      gir[1][n] && !ct_we[1] && !rst_go |=> !gir[1][n]); // R5
  end

  AST_UNIT_RESET_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> busy && full == '0 && gip == '0); // R9
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !a_irq && !b_irq); // R9
  AST_BUSY_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $stable(full) |=> $stable(full)); // R9
endmodule

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int RSTC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [5:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] last;

  always #2.5 clk = ~clk;

  ipc_mailbox #(.RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // behavioural model
  int m_slot [2][4];
  bit m_full [2][4], m_gip [2][4], m_gie [2][4], m_rie [2][4], m_tie [2][4], m_gir [2][4];
  int m_busy = 0;

  function automatic logic [31:0] m_read(int s, logic [5:0] ad);
    logic [31:0] v = 0;
    int n = ad[3:2];
    case (ad[5:4])
      2'd0: v = m_slot[s][n];
      2'd1: v = m_slot[1-s][n];
      2'd2: begin
        for (int k = 0; k < 4; k++) begin
          if (ad[3:2] == 0) begin
            v[28+3-k] = m_gip[s][k];
            v[24+3-k] = m_full[1-s][k];
            v[20+3-k] = !m_full[s][k];
          end else if (ad[3:2] == 1) begin
            v[28+3-k] = m_gie[s][k];
            v[24+3-k] = m_rie[s][k];
            v[20+3-k] = m_tie[s][k];
            v[16+3-k] = m_gir[s][k];
          end
        end
        if (ad[3:2] == 0) v[7] = (m_busy > 0);
      end
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit m_irq(int s);
    bit r = 0;
    for (int k = 0; k < 4; k++)
      r |= (m_gip[s][k] & m_gie[s][k]) | (m_full[1-s][k] & m_rie[s][k]) | (!m_full[s][k] & m_tie[s][k]);
    return r;
  endfunction

  task automatic model_step();
    bit isel [2]; bit iwr [2]; logic [5:0] iad [2]; logic [31:0] iwd [2];
    bit og [2][4];
    bit busy = (m_busy > 0);
    isel[0] = a_sel; iwr[0] = a_wr; iad[0] = a_addr; iwd[0] = a_wdata;
    isel[1] = b_sel; iwr[1] = b_wr; iad[1] = b_addr; iwd[1] = b_wdata;
    if (!busy && isel[0] && iwr[0] && iad[0][5:2] == 4'b1001 && iwd[0][5]) begin
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) begin
          m_slot[s][k] = 0; m_full[s][k] = 0; m_gip[s][k] = 0;
          m_gie[s][k] = 0; m_rie[s][k] = 0; m_tie[s][k] = 0; m_gir[s][k] = 0;
        end
      m_busy = RSTC;
      return;
    end
    if (busy) m_busy--;
    og = m_gir;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++) m_gir[s][k] = 0;
    for (int s = 0; s < 2; s++) begin
      if (!busy && isel[s] && !iwr[s] && iad[s][5:4] == 1) m_full[1-s][iad[s][3:2]] = 0;
      if (!busy && isel[s] && iwr[s] && iad[s][5:2] == 4'b1000)
        for (int k = 0; k < 4; k++) if (iwd[s][28+3-k]) m_gip[s][k] = 0;
    end
    for (int s = 0; s < 2; s++) begin
      if (!busy && isel[s] && iwr[s] && iad[s][5:4] == 0) begin
        m_slot[s][iad[s][3:2]] = iwd[s];
        m_full[s][iad[s][3:2]] = 1;
      end
      if (!busy && isel[s] && iwr[s] && iad[s][5:2] == 4'b1001)
        for (int k = 0; k < 4; k++) begin
          m_gie[s][k] = iwd[s][28+3-k]; m_rie[s][k] = iwd[s][24+3-k];
          m_tie[s][k] = iwd[s][20+3-k]; m_gir[s][k] = iwd[s][16+3-k];
        end
    end
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++) if (og[s][k]) m_gip[1-s][k] = 1;
  endtask

  always @(posedge clk) if (rst_n) model_step();

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #1;
    chk("R1 model a_rdata", a_rdata, m_read(0, a_addr));
    chk("R1 model b_rdata", b_rdata, m_read(1, b_addr));
    chk("R7 model a_irq", {31'b0, a_irq}, {31'b0, m_irq(0)});
    chk("R7 model b_irq", {31'b0, b_irq}, {31'b0, m_irq(1)});
  end

  task automatic acc(int s, bit w, logic [5:0] ad, logic [31:0] d);
    if (s == 0) begin a_sel = 1; a_wr = w; a_addr = ad; a_wdata = d; end
    else        begin b_sel = 1; b_wr = w; b_addr = ad; b_wdata = d; end
    #1 last = (s == 0) ? a_rdata : b_rdata;
    @(negedge clk);
    a_sel = 0; b_sel = 0;
  endtask

  task automatic rdchk(int s, logic [5:0] ad, logic [31:0] exp, string tag);
    acc(s, 0, ad, 0);
    chk(tag, last, exp);
  endtask

  task automatic pinchk(string tag, logic act, logic exp);
    #1 chk(tag, {31'b0, act}, {31'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    rdchk(0, 6'h20, 32'h00F00000, "R8 status A after reset");
    rdchk(1, 6'h20, 32'h00F00000, "R8 status B after reset");
    rdchk(0, 6'h24, 32'h0, "R8 control A after reset");
    pinchk("R8 irq A low", a_irq, 1'b0);
    // R2 / R1 / R3
    acc(0, 1, 6'h00, 32'h11111111);
    rdchk(0, 6'h20, 32'h00700000, "R2 A drained flag 0 cleared");
    rdchk(1, 6'h20, 32'h08F00000, "R2 B waiting flag 0 set");
    rdchk(1, 6'h10, 32'h11111111, "R1 B reads slot 0");
    rdchk(1, 6'h20, 32'h00F00000, "R3 B waiting flag cleared");
    rdchk(0, 6'h20, 32'h00F00000, "R3 A drained flag restored");
    acc(1, 1, 6'h08, 32'hA5A5F00D);
    rdchk(0, 6'h20, 32'h02F00000, "R2 A waiting flag 2");
    rdchk(1, 6'h08, 32'hA5A5F00D, "R1 B own slot readback");
    rdchk(0, 6'h18, 32'hA5A5F00D, "R1 A reads slot 2");
    // R4
    acc(0, 1, 6'h04, 32'h1);
    acc(0, 1, 6'h04, 32'h2);
    rdchk(1, 6'h20, 32'h04F00000, "R4 flags after overwrite");
    rdchk(1, 6'h14, 32'h2, "R4 overwrite wins");
    rdchk(1, 6'h14, 32'h2, "R4 empty read keeps word");
    rdchk(1, 6'h20, 32'h00F00000, "R4 empty read no flag change");
    // R5 doorbell
    acc(0, 1, 6'h24, 32'h00040000);
    rdchk(0, 6'h24, 32'h00040000, "R5 request visible one cycle");
    rdchk(0, 6'h24, 32'h0, "R5 request self-cleared");
    rdchk(1, 6'h20, 32'h40F00000, "R5 peer pending 1");
    pinchk("R7 irq B low without enable", b_irq, 1'b0);
    acc(1, 1, 6'h24, 32'h40000000);
    rdchk(1, 6'h24, 32'h40000000, "R10 enable readback");
    pinchk("R7 irq B on enabled doorbell", b_irq, 1'b1);
    // R6
    acc(1, 1, 6'h20, 32'h0);
    rdchk(1, 6'h20, 32'h40F00000, "R6 write 0 keeps pending");
    acc(1, 1, 6'h20, 32'h40000000);
    rdchk(1, 6'h20, 32'h00F00000, "R6 write 1 clears pending");
    pinchk("R7 irq B drops", b_irq, 1'b0);
    // R7 drained interrupt
    acc(0, 1, 6'h24, 32'h00100000);
    pinchk("R7 irq A on drained slot 3", a_irq, 1'b1);
    acc(0, 1, 6'h0C, 32'h33);
    pinchk("R7 irq A drops after fill", a_irq, 1'b0);
    rdchk(1, 6'h20, 32'h01F00000, "R2 B waiting flag 3");
    acc(0, 1, 6'h24, 32'hA5A00000);
    rdchk(0, 6'h24, 32'hA5A00000, "R10 mixed enables readback");
    // R9 unit reset
    acc(0, 1, 6'h24, 32'h00000020);
    rdchk(0, 6'h20, 32'h00F00080, "R9 busy cycle 1");
    acc(1, 1, 6'h00, 32'h55);
    rdchk(1, 6'h20, 32'h00F00080, "R9 busy cycle 3 on B");
    rdchk(0, 6'h20, 32'h00F00080, "R9 busy cycle 4");
    rdchk(0, 6'h20, 32'h00F00000, "R9 busy ended, write ignored");
    rdchk(0, 6'h10, 32'h0, "R9 slot cleared");
    rdchk(0, 6'h24, 32'h0, "R9 control A cleared");
    rdchk(1, 6'h24, 32'h0, "R9 control B cleared");
    acc(1, 1, 6'h24, 32'h00000020);
    rdchk(0, 6'h20, 32'h00F00000, "R9 side B reset bit ignored");
    rdchk(1, 6'h24, 32'h0, "R9 bit 5 reads 0");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule